// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general purpose I/O peripheral serving 32 pins. The pins are split into four banks of eight, and every bank answers to an identical 64-byte window of registers. Pin n lives in bank n>>3 at bit n&7, so bit 2 of bank 1 is pin 10. Software chooses per pin whether it is driven from an output latch or sampled as an input. The sampled levels pass through a two-stage synchroniser before anything reads them.

Each pin can also raise an interrupt. A pin in latched mode records a rising edge of its synchronised input in a status bit, and the bit stays set until software clears it. A pin in level mode has a status bit that simply tracks the synchronised input. Separate write addresses set and clear bits of a mask, and a set mask bit blocks that pin. One combined interrupt line is raised while any unblocked status bit is set in any bank. The host reaches the block through a simple synchronous register bus: byte address, write enable, write data, read enable and a registered read data.

Top module: `banked_pio`

## Requirements
- R1: Address bits 7:6 select the bank and bits 5:0 select a register within it. Offsets: 0x00 masked status, 0x04 status, 0x08 mask set and mask read, 0x0C mask clear, 0x10 direction, 0x14 output latch, 0x18 pin input, 0x20 level select. Pin n is bit n&7 of bank n>>3.
- R2: After reset every direction bit is 1 (all pins are inputs, pin_oe_o all 0), the output latch is 0, every status bit is 0, every mask bit is 1, every level select bit is 0, and irq_o is 0.
- R3: A direction bit of 0 makes the pin an output: pin_oe_o is 1 for it and pin_o carries its output latch bit. Direction (0x10) and the latch (0x14) read back what was written.
- R4: Offset 0x18 returns the pin levels after two synchroniser stages. A read issued in the cycle after a pin changes still returns the old level, and the read after that returns the new one. Writes to 0x18 are ignored.
- R5: With its level select bit 0, a pin sets its status bit (read at 0x04) on a rising edge of its synchronised input, and the bit stays set after the input falls. Writing 0x04 clears exactly the status bits written with 1.
- R6: With its level select bit 1 (written at 0x20, read back there), a pin's status bit equals its synchronised input; a clear written while the input stays high has no lasting effect, and the bit returns to 0 when the input goes low.
- R7: Writing 0x08 sets the mask bits written with 1, writing 0x0C clears the mask bits written with 1, and reading 0x08 returns the mask. Other mask bits keep their values.
- R8: Offset 0x00 returns status AND NOT mask and is read-only; writes to it are ignored.
- R9: irq_o is 1 exactly when some bank has a status bit set whose mask bit is 0.
- R10: rdata_o is loaded on the clock edge at which rd_en_i is 1 and is 0 after any edge without rd_en_i. Bits 31:8 read as 0 and are ignored on writes. Unmapped offsets, including the write-only 0x0C, read as 0.
- R11: A write to one bank changes no register of any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rdata_o | output | 32 | Read data, valid after the edge that sampled rd_en_i |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Output latch value per pin |
| pin_oe_o | output | 32 | Output enable per pin, 1 drives the pad |
| irq_o | output | 1 | Combined interrupt, OR of all unmasked status bits |

## Verification
Pins are raised one at a time in different banks so that a bank or bit decoding mistake shows as a wrong register value or a wrong bank responding. A latched-mode pin is pulsed and then released, which separates a held status from one that follows the level, while a level-mode pin is held high through a clear and then dropped, which separates the two modes the other way. Each event is viewed both masked and unmasked, reading raw status, masked status and the interrupt line, so a swapped set/clear mask port or an inverted mask is visible. A back-to-back read after a pin change measures the synchroniser depth.

// File: rtl/banked_pio_pkg.sv
package banked_pio_pkg;
  localparam int WIN_AW = 6;
  localparam logic [WIN_AW-1:0] OFF_MSTAT = 6'h00;
  localparam logic [WIN_AW-1:0] OFF_STAT  = 6'h04;
  localparam logic [WIN_AW-1:0] OFF_MSET  = 6'h08;
  localparam logic [WIN_AW-1:0] OFF_MCLR  = 6'h0C;
  localparam logic [WIN_AW-1:0] OFF_DIR   = 6'h10;
  localparam logic [WIN_AW-1:0] OFF_OUT   = 6'h14;
  localparam logic [WIN_AW-1:0] OFF_IN    = 6'h18;
  localparam logic [WIN_AW-1:0] OFF_LVL   = 6'h20;
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import banked_pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [WIN_AW-1:0] offset_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_sync_i,
  output logic [W-1:0]      rd_val_o,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic [W-1:0]      masked_o
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] out_q, out_d;
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] lvl_q, lvl_d;
  logic [W-1:0] prev_q;
  logic         wr_stat, wr_mset, wr_mclr, wr_dir, wr_out, wr_lvl;
  logic [W-1:0] rise, clr, keep;

  // write decode
  always_comb begin
    wr_stat = sel_i && wr_en_i && (offset_i == OFF_STAT);
    wr_mset = sel_i && wr_en_i && (offset_i == OFF_MSET);
    wr_mclr = sel_i && wr_en_i && (offset_i == OFF_MCLR);
    wr_dir  = sel_i && wr_en_i && (offset_i == OFF_DIR);
    wr_out  = sel_i && wr_en_i && (offset_i == OFF_OUT);
    wr_lvl  = sel_i && wr_en_i && (offset_i == OFF_LVL);
  end

  // next state
  always_comb begin
    rise  = pin_sync_i & ~prev_q;
    clr   = wr_stat ? wdata_i : '0;
    keep  = status_q & ~lvl_q & ~clr;
    dir_d = wr_dir ? wdata_i : dir_q;
    out_d = wr_out ? wdata_i : out_q;
    lvl_d = wr_lvl ? wdata_i : lvl_q;
    if (wr_mset)      mask_d = mask_q | wdata_i;
    else if (wr_mclr) mask_d = mask_q & ~wdata_i;
    else              mask_d = mask_q;
    status_d = (lvl_q & pin_sync_i) | (~lvl_q & ((status_q & ~clr) | rise));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '1;
      out_q    <= '0;
      status_q <= '0;
      mask_q   <= '1;
      lvl_q    <= '0;
      prev_q   <= '0;
    end else begin
      dir_q    <= dir_d;
      out_q    <= out_d;
      status_q <= status_d;
      mask_q   <= mask_d;
      lvl_q    <= lvl_d;
      prev_q   <= pin_sync_i;
    end
  end

  // read mux
  always_comb begin
    unique case (offset_i)
      OFF_MSTAT: rd_val_o = status_q & ~mask_q;
      OFF_STAT:  rd_val_o = status_q;
      OFF_MSET:  rd_val_o = mask_q;
      OFF_DIR:   rd_val_o = dir_q;
      OFF_OUT:   rd_val_o = out_q;
      OFF_IN:    rd_val_o = pin_sync_i;
      OFF_LVL:   rd_val_o = lvl_q;
      default:   rd_val_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
  assign masked_o = status_q & ~mask_q;

  assert_oe_follows_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == ~$past(wdata_i));

  assert_edge_status_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_q & $past(keep)) == $past(keep));

  assert_level_status_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q ^ $past(pin_sync_i)) & $past(lvl_q)) == '0);

  assert_mask_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> (mask_q & $past(wdata_i)) == $past(wdata_i));

  assert_mask_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mclr |=> (mask_q & $past(wdata_i)) == '0);
endmodule

// File: rtl/banked_pio.sv
module banked_pio
  import banked_pio_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 8,
  parameter int DATA_W = 32,
  localparam int SEL_W  = $clog2(NBANK),
  localparam int ADDR_W = SEL_W + WIN_AW,
  localparam int NPIN   = NBANK * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [NPIN-1:0]   pin_sync;
  logic [NPIN-1:0]   masked_all;
  logic [BANK_W-1:0] rd_val [NBANK];
  logic [SEL_W-1:0]  bank_sel;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pio_sync2 #(.W(NPIN)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  assign bank_sel = addr_i[ADDR_W-1 -: SEL_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pio_bank #(.W(BANK_W)) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_q),
      .sel_i      (bank_sel == SEL_W'(b)),
      .wr_en_i    (wr_en_i),
      .offset_i   (addr_i[WIN_AW-1:0]),
      .wdata_i    (wdata_i[BANK_W-1:0]),
      .pin_sync_i (pin_sync[b*BANK_W +: BANK_W]),
      .rd_val_o   (rd_val[b]),
      .pin_o      (pin_o[b*BANK_W +: BANK_W]),
      .pin_oe_o   (pin_oe_o[b*BANK_W +: BANK_W]),
      .masked_o   (masked_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en_i) rdata_d[BANK_W-1:0] = rd_val[bank_sel];
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |masked_all;

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !rd_en_i |=> rdata_o == '0);

  assert_upper_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    rdata_o[DATA_W-1:BANK_W] == '0);
endmodule

// File: tb/banked_pio_tb_top.sv
`timescale 1ns/1ps
module banked_pio_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wdata, rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  banked_pio dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R2 pin_oe after reset", pin_oe, 32'h0);
    check("R2 pin_o after reset", pin_out, 32'h0);
    check("R2 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h10, d); check("R2 direction bank0", d, 32'hFF);
    rd(8'hC8, d); check("R2 mask bank3", d, 32'hFF);
    rd(8'h54, d); check("R2 latch bank1", d, 32'h0);
    rd(8'hA0, d); check("R2 level select bank2", d, 32'h0);
    rd(8'h04, d); check("R2 status bank0", d, 32'h0);
  endtask

  task automatic t_dir_out;
    logic [31:0] d;
    wr(8'h50, 32'hF0);
    wr(8'h54, 32'h5A);
    idle(1);
    check("R3 pin_oe bank1", pin_oe, 32'h0000_0F00);
    check("R3 pin_o bank1", pin_out, 32'h0000_5A00);
    rd(8'h50, d); check("R3 direction readback", d, 32'hF0);
    rd(8'h54, d); check("R3 latch readback", d, 32'h5A);
    rd(8'h90, d); check("R11 bank2 direction untouched", d, 32'hFF);
    rd(8'h14, d); check("R11 bank0 latch untouched", d, 32'h0);
    wr(8'h50, 32'hFF);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h0000_0400;
    rd(8'h58, d); check("R4 first read still old level", d, 32'h0);
    rd(8'h58, d); check("R1 R4 pin 10 at bank1 bit2", d, 32'h04);
    wr(8'h58, 32'hFF);
    rd(8'h58, d); check("R4 input write ignored", d, 32'h04);
    rd(8'h18, d); check("R11 bank0 input unaffected", d, 32'h0);
    @(negedge clk); pin_in = 32'h0;
    idle(3);
    wr(8'h44, 32'hFF);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(8'h8C, 32'h08);
    @(negedge clk); pin_in = 32'h0008_0000;
    idle(4);
    rd(8'h84, d); check("R5 edge sets status pin19", d, 32'h08);
    rd(8'h80, d); check("R8 masked status pin19", d, 32'h08);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    rd(8'h84, d); check("R5 status holds after fall", d, 32'h08);
    wr(8'h84, 32'hF7);
    rd(8'h84, d); check("R5 clear of other bits no effect", d, 32'h08);
    wr(8'h84, 32'h08);
    rd(8'h84, d); check("R5 clear by write one", d, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    wr(8'h88, 32'h08);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'hE0, 32'h01);
    rd(8'hE0, d); check("R6 level select readback", d, 32'h01);
    wr(8'hCC, 32'h01);
    @(negedge clk); pin_in = 32'h0100_0000;
    idle(4);
    rd(8'hC4, d); check("R6 level status high", d, 32'h01);
    wr(8'hC4, 32'h01);
    idle(1);
    rd(8'hC4, d); check("R6 clear no lasting effect", d, 32'h01);
    check("R9 irq from level pin", {31'b0, irq}, 32'h1);
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    rd(8'hC4, d); check("R6 status follows low", d, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    wr(8'hC8, 32'h01);
    wr(8'hE0, 32'h00);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1;
    idle(4);
    @(negedge clk); pin_in = 32'h0;
    rd(8'h04, d); check("R5 bank0 pin0 status", d, 32'h01);
    rd(8'h00, d); check("R8 masked status blocked", d, 32'h0);
    check("R9 irq blocked by mask", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h01);
    rd(8'h08, d); check("R7 mask read after clear", d, 32'hFE);
    rd(8'h00, d); check("R8 masked status unblocked", d, 32'h01);
    check("R9 irq after unmask", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'hFF);
    rd(8'h04, d); check("R8 write to masked status ignored", d, 32'h01);
    wr(8'h08, 32'h01);
    rd(8'h08, d); check("R7 mask read after set", d, 32'hFF);
    check("R9 irq after remask", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h01);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FF3C);
    rd(8'h14, d); check("R10 upper bits dropped", d, 32'h3C);
    rd(8'h1C, d); check("R10 unmapped 0x1C", d, 32'h0);
    rd(8'h0C, d); check("R10 mask clear port reads 0", d, 32'h0);
    rd(8'h16, d); check("R10 unaligned reads 0", d, 32'h0);
    idle(1);
    check("R10 rdata zero when idle", rdata, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; pin_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_dir_out();
    t_input();
    t_edge();
    t_level();
    t_mask();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule